// File: doc/BRIEF.md
# Polynomial-Approximation Sine Synthesizer

This block is a direct digital frequency synthesizer that turns a frequency tuning word into a stream of signed sine samples. A phase accumulator advances by the tuning word on each enabled cycle. The top bits of that phase are folded into one quarter wave. A piecewise second-order polynomial, chosen by segment, then turns the folded phase into an amplitude. No full sine lookup table is used. The only storage is a small constant coefficient table with one row per segment.

The folded quarter wave has 256 steps and is split into eight segments. Within a segment the local variable is a centred odd integer `u` in -31..31. The polynomial is evaluated in Horner form, with one register after each multiply-add. The quadrant and valid bits travel beside the arithmetic through a matching delay line. The last stage rounds and saturates the magnitude and applies the sign. A two-state output controller holds the output at zero after reset (`ST_PRIME`). It moves to `ST_LIVE` on the first valid result and stays there until the next reset. In `ST_LIVE` the output keeps its last value whenever no new result arrives. The segment bit count and the polynomial order live in the package, next to the coefficient table.

Top module: `poly_sine_dds`

## Requirements
- R1: When `en` is sampled high, the block uses the current top 10 accumulator bits as that sample's phase P. It then adds `ftw` modulo 2^32. The accumulator starts at 0 after reset, so the first sample after reset has P = 0.
- R2: The amplitude for phase P stays within 2 LSB of 1023·sin(2π(P+0.5)/1024).
- R3: The output is never positive for P in 512..1023 and never negative for P in 0..511. The top phase bit selects negation.
- R4: Quadrant folding is exact. The amplitude for P equals the amplitude for 511−P, and the amplitude for P+512 equals the negated amplitude for P.
- R5: `amp_valid` is high for one cycle per accepted sample, exactly three clock edges after the edge that sampled `en`.
- R6: With `en` held high, a new result appears on every clock cycle.
- R7: A cycle with `en` low does not advance the phase. When `amp_valid` is low, `amp` keeps its previous value.
- R8: Reset clears the accumulator and the pipeline. `amp` is 0 and `amp_valid` is 0 until the first result arrives. The transition `ST_PRIME` → `ST_LIVE` happens on that first result.
- R9: The magnitude is saturated to 1023, so the code −1024 never appears. Peak samples (P = 255) reach at least 1021.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Accept a sample this cycle and advance the phase |
| ftw | input | 32 | Frequency tuning word added to the phase |
| amp | output | 11 | Signed sine amplitude |
| amp_valid | output | 1 | High for one cycle with each new amplitude |

## Verification
The hardest conditions to reach from the ports are the exact mirror relations between quadrants and the saturating peak near the quarter-wave edge. Each needs every one of the 1024 phase codes to be visited at a known position. The bench gets there with a unit phase step (tuning word 2^22) held for more than one full period, recording every amplitude by its phase. After the sweep it compares mirrored and negated pairs. Gapped enables with an odd tuning word, a reset in the middle of a stream, and a negative step that wraps the accumulator then cover hold, latency and restart.

// File: rtl/psd_pkg.sv
package psd_pkg;

    localparam int SEG_BITS = 3;
    localparam int SEG_N    = 1 << SEG_BITS;
    localparam int ORDER    = 2;
    localparam int COEF_W   = 16;
    // coefficient k carries FRAC0 + k*STEP_SH fraction bits
    localparam int FRAC0    = 4;
    localparam int STEP_SH  = 8;

    typedef logic signed [COEF_W-1:0] coef_t;

    // row = segment, column = power of u (0 .. ORDER); fitted around segment centres
    localparam coef_t COEF_TAB [SEG_N][ORDER+1] = '{
        '{16'sd1604,  16'sd12793, -16'sd495 },
        '{16'sd4751,  16'sd12302, -16'sd1465},
        '{16'sd7716,  16'sd11337, -16'sd2380},
        '{16'sd10384, 16'sd9937,  -16'sd3203},
        '{16'sd12653, 16'sd8155,  -16'sd3902},
        '{16'sd14435, 16'sd6060,  -16'sd4452},
        '{16'sd15663, 16'sd3732,  -16'sd4831},
        '{16'sd16289, 16'sd1260,  -16'sd5024}
    };

    typedef enum logic {ST_PRIME, ST_LIVE} out_state_e;

endpackage

// File: rtl/psd_phase_acc.sv
module psd_phase_acc #(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [ACC_W-1:0]   ftw,
    output logic [PHASE_W-1:0] phase
);

    logic [ACC_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst)     acc <= '0;
        else if (en) acc <= acc + ftw;
    end

    assign phase = acc[ACC_W-1 -: PHASE_W];

    assert_step_R1: assert property (@(posedge clk) disable iff (rst)
        en |=> (acc == $past(acc) + $past(ftw)));

    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc));

endmodule

// File: rtl/psd_quad_fold.sv
module psd_quad_fold #(
    parameter int PHASE_W  = 10,
    parameter int SEG_BITS = 3,
    localparam int QW      = PHASE_W - 2,
    localparam int X_W     = QW - SEG_BITS,
    localparam int U_W     = X_W + 2
) (
    input  logic [PHASE_W-1:0]   phase,
    output logic [SEG_BITS-1:0]  seg,
    output logic signed [U_W-1:0] u,
    output logic [1:0]           quad
);

    localparam int U_OFS = 1 << X_W;

    logic [QW-1:0]  inq;
    logic [X_W-1:0] x;

    always_comb begin
        quad = phase[PHASE_W-1 -: 2];
        // odd quadrants run the quarter wave backwards
        inq  = quad[0] ? ~phase[QW-1:0] : phase[QW-1:0];
        seg  = inq[QW-1 -: SEG_BITS];
        x    = inq[X_W-1:0];
        // centred odd offset: 2x+1 - 2^X_W
        u    = {1'b0, x, 1'b1} - U_W'(U_OFS);
    end

endmodule

// File: rtl/psd_horner_stage.sv
module psd_horner_stage #(
    parameter int POLY_W   = 24,
    parameter int U_W      = 7,
    parameter int SEG_BITS = 3,
    parameter int K        = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SEG_BITS-1:0]      seg,
    input  logic signed [U_W-1:0]    u,
    input  logic signed [POLY_W-1:0] acc_in,
    output logic signed [POLY_W-1:0] acc_out
);

    import psd_pkg::*;

    logic signed [POLY_W+U_W-1:0] prod;
    logic signed [POLY_W-1:0]     coef_ext;
    logic signed [POLY_W-1:0]     mac;

    always_comb begin
        prod     = acc_in * u;
        coef_ext = POLY_W'(COEF_TAB[seg][K]);
        mac      = POLY_W'(prod >>> STEP_SH) + coef_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) acc_out <= '0;
        else     acc_out <= mac;
    end

endmodule

// File: rtl/psd_out_stage.sv
module psd_out_stage #(
    parameter int POLY_W = 24,
    parameter int OUT_W  = 11
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     v_in,
    input  logic                     neg,
    input  logic signed [POLY_W-1:0] acc_in,
    output logic signed [OUT_W-1:0]  amp,
    output logic                     amp_valid
);

    import psd_pkg::*;

    localparam int MAG_W = OUT_W - 1;
    localparam int MAXV  = (1 << MAG_W) - 1;
    localparam int HALF  = 1 << (FRAC0 - 1);

    out_state_e state, state_nx;

    logic signed [POLY_W-1:0] rnd;
    logic [MAG_W-1:0]         mag;
    logic signed [OUT_W-1:0]  mag_s, amp_nx;

    always_comb begin
        rnd = (acc_in + POLY_W'(HALF)) >>> FRAC0;
        if (rnd < 0)                     mag = '0;
        else if (rnd > POLY_W'(MAXV))    mag = MAG_W'(MAXV);
        else                             mag = rnd[MAG_W-1:0];
        mag_s  = {1'b0, mag};
        amp_nx = neg ? -mag_s : mag_s;
    end

    always_comb begin
        unique case (state)
            ST_PRIME: state_nx = v_in ? ST_LIVE : ST_PRIME;
            ST_LIVE:  state_nx = ST_LIVE;
            default:  state_nx = ST_PRIME;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_PRIME;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            amp       <= '0;
            amp_valid <= 1'b0;
        end else begin
            amp_valid <= v_in;
            unique case (state)
                ST_PRIME: amp <= v_in ? amp_nx : '0;
                ST_LIVE:  if (v_in) amp <= amp_nx;
                default:  amp <= '0;
            endcase
        end
    end

    assert_sign_neg_R3: assert property (@(posedge clk) disable iff (rst)
        (v_in && neg) |=> (amp <= 0));

    assert_sign_pos_R3: assert property (@(posedge clk) disable iff (rst)
        (v_in && !neg) |=> (amp >= 0));

    assert_no_min_code_R9: assert property (@(posedge clk) disable iff (rst)
        amp_valid |-> (amp != {1'b1, {MAG_W{1'b0}}}));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !v_in |=> $stable(amp));

    assert_prime_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PRIME) |-> (amp == '0));

endmodule

// File: rtl/poly_sine_dds.sv
module poly_sine_dds #(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 10,
    parameter int OUT_W   = 11,
    parameter int POLY_W  = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [ACC_W-1:0]        ftw,
    output logic signed [OUT_W-1:0] amp,
    output logic                    amp_valid
);

    import psd_pkg::*;

    localparam int X_W = PHASE_W - 2 - SEG_BITS;
    localparam int U_W = X_W + 2;

    logic [PHASE_W-1:0]    phase;
    logic [SEG_BITS-1:0]   f_seg;
    logic signed [U_W-1:0] f_u;
    logic [1:0]            f_quad;

    // side delay line: one slot per Horner stage, plus one for the output stage
    logic [SEG_BITS-1:0]      d_seg  [ORDER];
    logic signed [U_W-1:0]    d_u    [ORDER];
    logic [1:0]               d_quad [ORDER+1];
    logic                     d_v    [ORDER+1];
    logic signed [POLY_W-1:0] h_out  [ORDER];
    logic signed [POLY_W-1:0] seed;

    psd_phase_acc #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_acc (
        .clk(clk), .rst(rst), .en(en), .ftw(ftw), .phase(phase)
    );

    psd_quad_fold #(.PHASE_W(PHASE_W), .SEG_BITS(SEG_BITS)) u_fold (
        .phase(phase), .seg(f_seg), .u(f_u), .quad(f_quad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ORDER; i++) begin
                d_seg[i] <= '0;
                d_u[i]   <= '0;
            end
            for (int i = 0; i <= ORDER; i++) begin
                d_quad[i] <= '0;
                d_v[i]    <= 1'b0;
            end
        end else begin
            d_seg[0]  <= f_seg;
            d_u[0]    <= f_u;
            d_quad[0] <= f_quad;
            d_v[0]    <= en;
            for (int i = 1; i < ORDER; i++) begin
                d_seg[i] <= d_seg[i-1];
                d_u[i]   <= d_u[i-1];
            end
            for (int i = 1; i <= ORDER; i++) begin
                d_quad[i] <= d_quad[i-1];
                d_v[i]    <= d_v[i-1];
            end
        end
    end

    assign seed = POLY_W'(COEF_TAB[d_seg[0]][ORDER]);

    for (genvar g = 0; g < ORDER; g++) begin : g_horner
        if (g == 0) begin : g_first
            psd_horner_stage #(.POLY_W(POLY_W), .U_W(U_W), .SEG_BITS(SEG_BITS),
                               .K(ORDER-1-g)) u_stage (
                .clk(clk), .rst(rst), .seg(d_seg[g]), .u(d_u[g]),
                .acc_in(seed), .acc_out(h_out[g])
            );
        end else begin : g_next
            psd_horner_stage #(.POLY_W(POLY_W), .U_W(U_W), .SEG_BITS(SEG_BITS),
                               .K(ORDER-1-g)) u_stage (
                .clk(clk), .rst(rst), .seg(d_seg[g]), .u(d_u[g]),
                .acc_in(h_out[g-1]), .acc_out(h_out[g])
            );
        end
    end

    psd_out_stage #(.POLY_W(POLY_W), .OUT_W(OUT_W)) u_out (
        .clk(clk), .rst(rst), .v_in(d_v[ORDER]), .neg(d_quad[ORDER][1]),
        .acc_in(h_out[ORDER-1]), .amp(amp), .amp_valid(amp_valid)
    );

endmodule

// File: tb/tb_poly_sine_dds.sv
`timescale 1ns/1ps
module tb_poly_sine_dds;

    localparam int DLY = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en  = 1'b0;
    logic [31:0]       ftw = '0;
    logic signed [10:0] amp;
    logic              amp_valid;

    always #2.5 clk = ~clk;

    poly_sine_dds dut (
        .clk(clk), .rst(rst), .en(en), .ftw(ftw), .amp(amp), .amp_valid(amp_valid)
    );

    int n_chk = 0;
    int n_err = 0;
    bit chk_on = 1'b0;

    int          dq[$] = '{-1, -1, -1};
    logic [31:0] macc = '0;
    int          exp_ph = -1;
    int          last_amp = 0;
    int          amp_at[1024];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // behavioural reference: delay queue of phases plus a plain accumulator
    always @(posedge clk) begin
        if (rst) begin
            dq = '{-1, -1, -1};
            macc = '0;
            exp_ph = -1;
            last_amp = 0;
        end else begin
            exp_ph = dq.pop_front();
            dq.push_back(en ? int'(macc[31:22]) : -1);
            if (en) macc = macc + ftw;
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            if (exp_ph < 0) begin
                chk(amp_valid == 1'b0, "R5 no result expected", int'(amp_valid), 0);
                chk(int'(amp) == last_amp, "R7 hold while invalid", int'(amp), last_amp);
            end else begin
                real r;
                real d;
                r = 1023.0 * $sin(2.0 * 3.14159265358979 * (real'(exp_ph) + 0.5) / 1024.0);
                d = real'(amp) - r;
                chk(amp_valid == 1'b1, "R5 R6 result expected", int'(amp_valid), 1);
                chk(d <= 2.0 && d >= -2.0, "R2 amplitude vs sine (phase per R1)",
                    int'(amp), int'($rtoi(r + (r >= 0.0 ? 0.5 : -0.5))));
                if (exp_ph >= 512) chk(amp <= 0, "R3 sign in lower half", int'(amp), 0);
                else               chk(amp >= 0, "R3 sign in upper half", int'(amp), 0);
                chk(amp >= -1023 && amp <= 1023, "R9 magnitude bound", int'(amp), 1023);
                amp_at[exp_ph] = int'(amp);
                last_amp = int'(amp);
            end
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) amp_at[i] = -9999;
        @(posedge clk);
        chk_on = 1'b1;
        repeat (3) @(negedge clk);
        chk(amp == 0 && amp_valid == 1'b0, "R8 reset state", int'(amp), 0);
        rst = 1'b0;

        // full-period unit-step sweep, back to back
        ftw = 32'h0040_0000;
        en  = 1'b1;
        repeat (1032) @(negedge clk);
        en = 1'b0;
        repeat (6) @(negedge clk);

        chk(amp_at[0] >= 1 && amp_at[0] <= 5, "R1 first sample uses phase 0", amp_at[0], 3);
        for (int p = 0; p < 256; p++)
            chk(amp_at[p] == amp_at[511 - p], "R4 mirror pair", amp_at[511 - p], amp_at[p]);
        for (int p = 0; p < 512; p++)
            chk(amp_at[p + 512] == -amp_at[p], "R4 negated half", amp_at[p + 512], -amp_at[p]);
        chk(amp_at[255] >= 1021, "R9 positive peak", amp_at[255], 1023);
        chk(amp_at[767] <= -1021, "R9 negative peak", amp_at[767], -1023);

        // gapped enables with an odd tuning word
        begin
            logic [15:0] lf;
            lf  = 16'hACE1;
            ftw = 32'h0123_4567;
            for (int i = 0; i < 400; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                en = lf[0];
                @(negedge clk);
            end
        end

        // reset in the middle of a stream
        en  = 1'b1;
        ftw = 32'h0FED_CBA9;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(amp == 0 && amp_valid == 1'b0, "R8 reset mid-stream", int'(amp), 0);
        rst = 1'b0;
        repeat (30) @(negedge clk);

        // negative step wraps the accumulator below zero
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ftw = 32'hFFC0_0000;
        repeat (300) @(negedge clk);
        en = 1'b0;
        repeat (8) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule